// File: doc/BRIEF.md
# Parity-Inserting Memory Initializer

This block returns a range of 36-bit memory words to a known clean state once a memory test has finished. Each word is split into three write slices: a 16-bit low slice, a 16-bit middle slice and a 4-bit high slice. The low and high slices share one write strobe. The middle slice has its own strobe. Every word gets all-zero data plus a parity bit that makes the total number of ones in the 36 bits odd.

The parity bit is computed in logic. The three slices of the pre-parity fill word are XOR-merged. The merged word is then folded in halves, 16 to 8 to 4 to 2 to 1, and the result is inverted. The bit is XORed into the top bit of the middle slice, so no separate parity column is needed.

A one-cycle start pulse captures the first and last addresses. The sequencer then walks the range in ascending order, one address every two cycles. A one-cycle done pulse follows the last write.

Top module: `mem_parity_init`

## Requirements
- R1: After reset, and until a start pulse is accepted, both write strobes and the done output are low.
- R2: For each address, the low/high strobe is high for one cycle and the middle strobe is high in the next cycle. Both cycles present the same address. The two strobes are never high together.
- R3: The addresses written run in ascending order from the captured first address to the captured last address, inclusive. Each address is written exactly once.
- R4: In every write, the low slice and the high slice are zero and the middle slice is 16'h8000, so parity sits in bit 15 of the middle slice (word bit 31). The 36-bit word has an odd number of ones.
- R5: The parity bit comes from a halving fold (16 to 8 to 4 to 2 to 1) of the XOR of the three slices, then inverted. It equals the inverted reduction XOR of all 36 fill bits.
- R6: Done is high for exactly one cycle: the cycle right after the last middle-slice write. No strobe is high while done is high.
- R7: A start pulse that arrives while a walk is in progress is ignored. The walk neither restarts nor changes its range.
- R8: If the first address is greater than the last address, no write strobe rises and done is high in the cycle after the start pulse.
- R9: A range whose first and last addresses are equal writes exactly one word.
- R10: The first and last addresses are sampled only on an accepted start pulse. Later changes on those inputs have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a walk |
| first_addr_i | input | ADDR_W | First address of the range |
| last_addr_i | input | ADDR_W | Last address of the range, inclusive |
| wr_addr_o | output | ADDR_W | Address of the current write |
| wr_lo_o | output | 1 | Strobe for the low and high slices |
| wr_mid_o | output | 1 | Strobe for the middle slice |
| wr_data_lo_o | output | LO_W | Low slice data |
| wr_data_mid_o | output | MID_W | Middle slice data, including the parity bit |
| wr_data_hi_o | output | HI_W | High slice data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are a start pulse landing in the middle of a walk together with new values on the address inputs, and a walk that ends at the all-ones address, where a wrapping increment would go unnoticed. The bench reaches the first by re-pulsing start with a disturbed range during the first middle-slice cycle of selected runs. It reaches the second by running a range whose last address is the top of the address space. A sweep over every first/last pair in a small window covers empty, single-word and multi-word ranges, with the address sequence predicted from arithmetic alone.

// File: rtl/mpi_pkg.sv
package mpi_pkg;
  typedef enum logic [1:0] {
    MPI_IDLE = 2'd0,
    MPI_LOW  = 2'd1,
    MPI_MID  = 2'd2
  } mpi_state_e;
endpackage

// File: rtl/mpi_rst_sync.sv
module mpi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mpi_parity_fold.sv
module mpi_parity_fold #(
  parameter int LO_W  = 16,
  parameter int MID_W = 16,
  parameter int HI_W  = 4
) (
  input  logic [LO_W-1:0]  lo_i,
  input  logic [MID_W-1:0] mid_i,
  input  logic [HI_W-1:0]  hi_i,
  output logic             odd_par_o
);
  localparam int FW  = LO_W;
  localparam int LVL = $clog2(FW);

  logic [FW-1:0] stage [0:LVL];

  always_comb begin
    stage[0] = lo_i ^ mid_i ^ {{(FW-HI_W){1'b0}}, hi_i};
  end

  for (genvar g = 0; g < LVL; g++) begin : g_fold
    localparam int HALF = FW >> (g + 1);
    always_comb begin
      stage[g+1] = '0;
      stage[g+1][HALF-1:0] = stage[g][2*HALF-1:HALF] ^ stage[g][HALF-1:0];
    end
  end

  assign odd_par_o = ~stage[LVL][0];

  always_comb begin
    assert_fold_matches_R5: assert (odd_par_o == ~(^{hi_i, mid_i, lo_i}))
      else $error("parity fold differs from reduction");
  end
endmodule

// File: rtl/mpi_addr_walk.sv
module mpi_addr_walk #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] last_o,
  output logic              at_end_o
);
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              cur_en, last_en;

  always_comb begin
    cur_en  = load_i | step_i;
    last_en = load_i;
    cur_d   = load_i ? first_i : cur_q + ADDR_W'(1);
    last_d  = last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      if (cur_en)  cur_q  <= cur_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign cur_o    = cur_q;
  assign last_o   = last_q;
  assign at_end_o = (cur_q == last_q);
endmodule

// File: rtl/mpi_ctrl.sv
module mpi_ctrl
  import mpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic range_ok_i,
  input  logic at_end_i,
  output logic load_o,
  output logic step_o,
  output logic stb_lo_o,
  output logic stb_mid_o,
  output logic done_o
);
  mpi_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      MPI_IDLE: begin
        if (start_i) begin
          if (range_ok_i) begin
            load_o  = 1'b1;
            state_d = MPI_LOW;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      MPI_LOW: state_d = MPI_MID;
      MPI_MID: begin
        if (at_end_i) begin
          state_d = MPI_IDLE;
          done_d  = 1'b1;
        end else begin
          step_o  = 1'b1;
          state_d = MPI_LOW;
        end
      end
      default: state_d = MPI_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MPI_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign stb_lo_o  = (state_q == MPI_LOW);
  assign stb_mid_o = (state_q == MPI_MID);
  assign done_o    = done_q;

  assert_strobe_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_lo_o |=> stb_mid_o);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_lo_o && stb_mid_o));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(stb_lo_o || stb_mid_o));
  assert_empty_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MPI_IDLE && start_i && !range_ok_i) |=> (done_o && !stb_lo_o));
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_lo_o && start_i) |=> stb_mid_o);
endmodule

// File: rtl/mem_parity_init.sv
module mem_parity_init #(
  parameter int ADDR_W = 12,
  parameter int LO_W   = 16,
  parameter int MID_W  = 16,
  parameter int HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_lo_o,
  output logic              wr_mid_o,
  output logic [LO_W-1:0]   wr_data_lo_o,
  output logic [MID_W-1:0]  wr_data_mid_o,
  output logic [HI_W-1:0]   wr_data_hi_o,
  output logic              done_o
);
  localparam int PAR_POS = MID_W - 1;

  logic              rst_n_s;
  logic              load, step, at_end, range_ok, par;
  logic [ADDR_W-1:0] last_cap;
  logic [LO_W-1:0]   fill_lo;
  logic [MID_W-1:0]  fill_mid;
  logic [HI_W-1:0]   fill_hi;

  assign fill_lo  = '0;
  assign fill_mid = '0;
  assign fill_hi  = '0;
  assign range_ok = (first_addr_i <= last_addr_i);

  mpi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mpi_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .range_ok_i (range_ok),
    .at_end_i   (at_end),
    .load_o     (load),
    .step_o     (step),
    .stb_lo_o   (wr_lo_o),
    .stb_mid_o  (wr_mid_o),
    .done_o     (done_o)
  );

  mpi_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (load),
    .step_i   (step),
    .first_i  (first_addr_i),
    .last_i   (last_addr_i),
    .cur_o    (wr_addr_o),
    .last_o   (last_cap),
    .at_end_o (at_end)
  );

  mpi_parity_fold #(.LO_W(LO_W), .MID_W(MID_W), .HI_W(HI_W)) u_par (
    .lo_i      (fill_lo),
    .mid_i     (fill_mid),
    .hi_i      (fill_hi),
    .odd_par_o (par)
  );

  always_comb begin
    wr_data_lo_o           = fill_lo;
    wr_data_hi_o           = fill_hi;
    wr_data_mid_o          = fill_mid;
    wr_data_mid_o[PAR_POS] = fill_mid[PAR_POS] ^ par;
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_mid_o && wr_addr_o != last_cap) |=> (wr_lo_o && wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)));
  assert_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_lo_o |=> (wr_addr_o == $past(wr_addr_o)));
  assert_range_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_lo_o |=> (last_cap == $past(last_cap)));
  assert_odd_word_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_mid_o |-> ($countones({wr_data_hi_o, wr_data_mid_o, wr_data_lo_o}) % 2 == 1));
endmodule

// File: tb/tb_mem_parity_init.sv
module tb_mem_parity_init;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] first_addr_i, last_addr_i;
  logic [AW-1:0] wr_addr_o;
  logic          wr_lo_o, wr_mid_o, done_o;
  logic [15:0]   wr_data_lo_o, wr_data_mid_o;
  logic [3:0]    wr_data_hi_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mem_parity_init #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .first_addr_i(first_addr_i), .last_addr_i(last_addr_i),
    .wr_addr_o(wr_addr_o), .wr_lo_o(wr_lo_o), .wr_mid_o(wr_mid_o),
    .wr_data_lo_o(wr_data_lo_o), .wr_data_mid_o(wr_data_mid_o),
    .wr_data_hi_o(wr_data_hi_o), .done_o(done_o)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one walk; disturb re-pulses start with a different range mid-walk (R7, R10)
  task automatic run(input int s, input int e, input bit disturb);
    int bad_seq = 0, bad_dat = 0, n_lo = 0;
    @(negedge clk);
    first_addr_i = AW'(s);
    last_addr_i  = AW'(e);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      first_addr_i = AW'(e + 7);
      last_addr_i  = AW'(s);
    end
    if (s > e) begin
      check(done_o && !wr_lo_o && !wr_mid_o, "R8", "empty range done", {wr_lo_o, wr_mid_o, done_o}, 1);
      @(negedge clk);
      check(!done_o && !wr_lo_o && !wr_mid_o, "R8", "empty range quiet", {wr_lo_o, wr_mid_o, done_o}, 0);
      return;
    end
    for (int a = s; a <= e; a++) begin
      if (!(wr_lo_o && !wr_mid_o && !done_o && wr_addr_o == AW'(a))) begin
        if (bad_seq == 0)
          $display("FAIL R3 low phase addr: actual 0x%0h expected 0x%0h (lo=%0b)", wr_addr_o, a, wr_lo_o);
        bad_seq++;
      end
      if (wr_data_lo_o != 16'h0 || wr_data_hi_o != 4'h0) bad_dat++;
      n_lo++;
      @(negedge clk);
      if (disturb && a == s) start_i = 1'b1;
      if (!(wr_mid_o && !wr_lo_o && wr_addr_o == AW'(a))) begin
        if (bad_seq == 0)
          $display("FAIL R2 mid phase addr: actual 0x%0h expected 0x%0h (mid=%0b)", wr_addr_o, a, wr_mid_o);
        bad_seq++;
      end
      if (wr_data_mid_o != 16'h8000 ||
          ($countones({wr_data_hi_o, wr_data_mid_o, wr_data_lo_o}) % 2) != 1) bad_dat++;
      @(negedge clk);
      start_i = 1'b0;
    end
    tests = tests + 1;
    if (bad_seq != 0) fails = fails + 1;
    check(bad_dat == 0, "R4", "data/parity errors", bad_dat, 0);
    check(n_lo == e - s + 1, "R9", "word count", n_lo, e - s + 1);
    check(done_o && !wr_lo_o && !wr_mid_o, "R6", "done after last", {wr_lo_o, wr_mid_o, done_o}, 1);
    @(negedge clk);
    check(!done_o && !wr_lo_o, "R6", "done single pulse", {wr_lo_o, done_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    first_addr_i = '0;
    last_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(!wr_lo_o && !wr_mid_o && !done_o, "R1", "reset quiet", {wr_lo_o, wr_mid_o, done_o}, 0);
      @(negedge clk);
    end
    // R5: the fold result shows as bit 15 of the middle slice
    check(wr_data_mid_o == 16'h8000, "R5", "parity bit position", wr_data_mid_o, 16'h8000);
    // sweep every first/last pair in a small window: empty, single (R9), multi (R3)
    for (int s = 0; s < 16; s++)
      for (int e = 0; e < 16; e++)
        run(s, e, 1'b0);
    // start while busy and input changes mid-walk (R7, R10)
    run(3, 9, 1'b1);
    run(5, 5, 1'b1);
    run(40, 60, 1'b1);
    // top of address space, no wrap (R3)
    run(4090, 4095, 1'b0);
    // full default range (R3)
    run(256, 3583, 1'b0);
    summary();
  end
endmodule